// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block follows a chain of control blocks in memory for a single DMA channel. Each control block occupies consecutive 64-bit words. Word 0 holds the address of the next control block in bits [31:0]. Word 1 holds the INFO word in bits [31:0]. After these come one word per data buffer, and the count of buffer words is set per channel. A buffer word carries the buffer address in bits [63:32] and its status in bits [31:0]. The status bits [15:0] give the buffer length in bytes, bit 31 is the done flag and bit 30 is the end-of-frame flag.

For every buffer word the walker takes these steps in order:
- It offers the buffer address, length and INFO to a downstream data mover over a valid/ready handshake.
- It writes the buffer word back with the status flags updated.
- It moves on to the next buffer word.

When the last buffer of a control block has been written back, the walker raises a frame interrupt and follows the next pointer. A next pointer of zero ends the chain. In that case the walker raises a list-refill interrupt and waits for software to arm it again.

Memory reads use a single-beat request/grant port, and each read completes with an in-order response valid. Writes use a request/grant port that completes with an acknowledge. Only one transfer is in flight at any time. An extraction-mode input enables the buffer alignment and length rules. Any violation, a misaligned control-block pointer or a zero buffer count stops the walk and sets a fault flag.

Top module: `dwalk_top`

## Requirements
- R1: An accepted arm reads the start address, then start+8, then start+16+8k for buffer k. Only one read is in flight at a time, and a request holds its address until it is granted.
- R2: Each control block causes exactly N buffer-word reads, where N (1 to 15) is the count latched at arm.
- R3: Each buffer is offered with dm_ptr = word[63:32], dm_len = word[15:0] and dm_info = INFO[31:0]. dm_last is high only for the final buffer of the block. The offer holds until dm_ready.
- R4: After dm_ready the walker writes to the same buffer-word address. The write data is {ptr, 1, last, status[29:0]}: the done bit is set and the end-of-frame bit is set only on the final buffer. The next read waits for the write acknowledge.
- R5: irq_frame pulses for one cycle after the acknowledge of the final buffer's write-back of each control block, and at no other time.
- R6: After a block, the walk continues at the next pointer. A zero next pointer pulses irq_list and returns the walker to idle.
- R7: An arm with start[2:0] != 0 or a count of 0 sets fault and issues no read. A next pointer with bits [2:0] != 0 sets fault and is not fetched.
- R8: In extraction mode, a buffer word with ptr[2:0] != 0 or len[6:0] != 0 sets fault. That buffer is neither offered nor written back. In injection mode the same buffer is accepted.
- R9: An arm while busy is ignored. An accepted arm clears fault.
- R10: After reset: busy, fault, rd_req, wr_req, dm_valid, irq_frame and irq_list are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a walk (taken only while idle) |
| start_ptr | input | 32 | Address of the first control block |
| blk_cnt | input | 4 | Buffer words per control block |
| extract | input | 1 | 1 = extraction mode (buffer rules enabled) |
| busy | output | 1 | Walk in progress |
| fault | output | 1 | Sticky error flag, cleared on an accepted arm |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_gnt | input | 1 | Read grant |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 64 | Read response data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write data |
| wr_gnt | input | 1 | Write grant |
| wr_ack | input | 1 | Write completion |
| dm_valid | output | 1 | Buffer offer valid |
| dm_ready | input | 1 | Data mover accepts the offer |
| dm_ptr | output | 32 | Buffer address |
| dm_len | output | 16 | Buffer length in bytes |
| dm_info | output | 32 | INFO word of the current block |
| dm_last | output | 1 | Final buffer of the block |
| irq_frame | output | 1 | Frame-done pulse |
| irq_list | output | 1 | List-refill pulse |

## Verification
The hardest case to reach from the ports is a fault in the middle of a chain. One example is a bad buffer that follows buffers already written back in an earlier block. Another is a misaligned next pointer that is only seen after a full block has completed. In both cases the walker must stop exactly there, with no stray read, offer or write.

The bench builds each chain in a memory model and derives the exact expected read, offer and write sequences from its own layout rules. It places the defect at a chosen block and buffer. The grant, response, ready and acknowledge delays are randomized, so the stop point arrives under many different handshake timings.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
  localparam int unsigned PTR_W  = 32;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned LEN_GRAIN_BITS = 7;  // 128-byte multiple
  localparam int unsigned DONE_BIT = 31;
  localparam int unsigned EOF_BIT  = 30;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_OFFER = 2'd2,
    ST_WRITE = 2'd3
  } walk_st_e;

  function automatic logic [PTR_W-1:0] word_addr(input logic [PTR_W-1:0] base,
                                                 input logic [PTR_W-1:0] idx);
    return base + (idx << 3);
  endfunction

  function automatic logic is_dword_aligned(input logic [PTR_W-1:0] p);
    return (p[2:0] == 3'b000);
  endfunction

  function automatic logic len_grain_ok(input logic [LEN_W-1:0] len);
    return (len[LEN_GRAIN_BITS-1:0] == '0);
  endfunction

  function automatic logic [WORD_W-1:0] writeback_word(input logic [WORD_W-1:0] w,
                                                       input logic last);
    logic [WORD_W-1:0] r;
    r = w;
    r[DONE_BIT] = 1'b1;
    r[EOF_BIT]  = last;
    return r;
  endfunction
endpackage

// File: rtl/dwalk_xfer.sv
module dwalk_xfer #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          req,
  output logic [AW-1:0] addr,
  input  logic          gnt,
  input  logic          resp,
  output logic          done
);
  typedef enum logic [1:0] {X_IDLE, X_REQ, X_WAIT} xst_e;
  xst_e st_q;

  assign req  = (st_q == X_REQ);
  assign done = (st_q == X_WAIT) && resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= X_IDLE;
      addr <= '0;
    end else if (go) begin
      st_q <= X_REQ;
      addr <= go_addr;
    end else begin
      case (st_q)
        X_REQ:   if (gnt)  st_q <= X_WAIT;
        X_WAIT:  if (resp) st_q <= X_IDLE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  // R1: a request keeps its address until granted
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !gnt |=> req && $stable(addr));
  // R1: a new transfer starts only when the previous one is finished
  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == X_IDLE) || done);
endmodule

// File: rtl/dwalk_chk.sv
module dwalk_chk
  import dwalk_pkg::*;
(
  input  logic             extract,
  input  logic [WORD_W-1:0] word,
  output logic             buf_ok
);
  logic [PTR_W-1:0] buf_ptr;
  logic [LEN_W-1:0] buf_len;
  logic             ptr_bad;
  logic             len_bad;

  assign buf_ptr = word[WORD_W-1:WORD_W-PTR_W];
  assign buf_len = word[LEN_W-1:0];
  assign ptr_bad = !is_dword_aligned(buf_ptr);
  assign len_bad = !len_grain_ok(buf_len);
  assign buf_ok  = !extract || !(ptr_bad || len_bad);
endmodule

// File: rtl/dwalk_top.sv
module dwalk_top
  import dwalk_pkg::*;
#(
  parameter int unsigned MAX_BLKS = 15,
  localparam int unsigned CW = $clog2(MAX_BLKS + 1),
  localparam int unsigned IW = CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [CW-1:0]     blk_cnt,
  input  logic              extract,
  output logic              busy,
  output logic              fault,
  output logic              rd_req,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  input  logic [WORD_W-1:0] rd_rdata,
  output logic              wr_req,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_gnt,
  input  logic              wr_ack,
  output logic              dm_valid,
  input  logic              dm_ready,
  output logic [PTR_W-1:0]  dm_ptr,
  output logic [LEN_W-1:0]  dm_len,
  output logic [PTR_W-1:0]  dm_info,
  output logic              dm_last,
  output logic              irq_frame,
  output logic              irq_list
);
  walk_st_e          st_q;
  logic [PTR_W-1:0]  base_q, next_q, info_q;
  logic [IW-1:0]     idx_q;
  logic [CW-1:0]     cnt_q;
  logic              mode_q;
  logic [WORD_W-1:0] pair_q;
  logic              fault_q, irq_frame_q, irq_list_q;

  // named internal events
  logic             rd_done, wr_done, rd_go, wr_go;
  logic [PTR_W-1:0] rd_go_addr;
  logic             arm_take, arm_good, hdr_fin, pair_fin, pair_ok;
  logic             offer_take, wb_fin, pair_last, blk_end;
  logic             next_zero, next_ok;

  assign arm_take   = (st_q == ST_IDLE) && arm;
  assign arm_good   = arm_take && is_dword_aligned(start_ptr) && (blk_cnt != '0);
  assign hdr_fin    = (st_q == ST_READ) && rd_done && (idx_q < IW'(2));
  assign pair_fin   = (st_q == ST_READ) && rd_done && (idx_q >= IW'(2));
  assign pair_last  = (idx_q == IW'(cnt_q) + IW'(1));
  assign offer_take = (st_q == ST_OFFER) && dm_ready;
  assign wb_fin     = (st_q == ST_WRITE) && wr_done;
  assign blk_end    = wb_fin && pair_last;
  assign next_zero  = (next_q == '0);
  assign next_ok    = !next_zero && is_dword_aligned(next_q);

  assign rd_go = arm_good || hdr_fin || (wb_fin && !pair_last) || (blk_end && next_ok);
  always_comb begin
    if (arm_good)     rd_go_addr = start_ptr;
    else if (blk_end) rd_go_addr = next_q;
    else              rd_go_addr = word_addr(base_q, PTR_W'(idx_q + IW'(1)));
  end
  assign wr_go = offer_take;

  dwalk_xfer #(.AW(PTR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .go_addr(rd_go_addr),
    .req(rd_req), .addr(rd_addr), .gnt(rd_gnt), .resp(rd_rvalid), .done(rd_done)
  );

  dwalk_xfer #(.AW(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(wr_go),
    .go_addr(word_addr(base_q, PTR_W'(idx_q))),
    .req(wr_req), .addr(wr_addr), .gnt(wr_gnt), .resp(wr_ack), .done(wr_done)
  );

  dwalk_chk u_chk (.extract(mode_q), .word(rd_rdata), .buf_ok(pair_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      base_q      <= '0;
      next_q      <= '0;
      info_q      <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      mode_q      <= 1'b0;
      pair_q      <= '0;
      fault_q     <= 1'b0;
      irq_frame_q <= 1'b0;
      irq_list_q  <= 1'b0;
    end else begin
      irq_frame_q <= 1'b0;
      irq_list_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (arm_good) begin
            base_q  <= start_ptr;
            idx_q   <= '0;
            cnt_q   <= blk_cnt;
            mode_q  <= extract;
            fault_q <= 1'b0;
            st_q    <= ST_READ;
          end else if (arm_take) begin
            fault_q <= 1'b1;
          end
        end
        ST_READ: begin
          if (hdr_fin) begin
            if (idx_q == '0) next_q <= rd_rdata[PTR_W-1:0];
            else             info_q <= rd_rdata[PTR_W-1:0];
            idx_q <= idx_q + IW'(1);
          end else if (pair_fin) begin
            if (pair_ok) begin
              pair_q <= rd_rdata;
              st_q   <= ST_OFFER;
            end else begin
              fault_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        ST_OFFER: if (offer_take) st_q <= ST_WRITE;
        ST_WRITE: begin
          if (wb_fin && !pair_last) begin
            idx_q <= idx_q + IW'(1);
            st_q  <= ST_READ;
          end else if (blk_end) begin
            irq_frame_q <= 1'b1;
            if (next_zero) begin
              irq_list_q <= 1'b1;
              st_q       <= ST_IDLE;
            end else if (next_ok) begin
              base_q <= next_q;
              idx_q  <= '0;
              st_q   <= ST_READ;
            end else begin
              fault_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign fault     = fault_q;
  assign irq_frame = irq_frame_q;
  assign irq_list  = irq_list_q;
  assign dm_valid  = (st_q == ST_OFFER);
  assign dm_ptr    = pair_q[WORD_W-1:WORD_W-PTR_W];
  assign dm_len    = pair_q[LEN_W-1:0];
  assign dm_info   = info_q;
  assign dm_last   = pair_last;
  assign wr_data   = writeback_word(pair_q, pair_last);

  // R1: reads and writes never overlap on the request side
  a_r1_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  // R1: every read targets a 64-bit aligned word
  a_r1_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[2:0] == 3'b000);
  // R3: an offer holds steady until accepted
  a_r3_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid && !dm_ready |=> dm_valid && $stable(dm_ptr) && $stable(dm_len) && $stable(dm_last));
  // R4: a write request is only made after an accepted offer
  a_r4_wr_after_offer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(dm_valid && dm_ready));
  // R5: the frame interrupt lasts one cycle
  a_r5_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |=> !irq_frame);
  // R6: the list interrupt coincides with a frame end and an idle walker
  a_r6_list_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_list |-> irq_frame && !busy);
  // R7: a fault leaves the walker idle
  a_r7_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);
  // R8: buffers offered in extraction mode obey both rules
  a_r8_extract_rules: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid && mode_q |-> dm_ptr[2:0] == 3'b000 && dm_len[6:0] == 7'd0);
endmodule

// File: tb/dwalk_top_bench.sv
module dwalk_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [31:0] start_ptr = '0;
  logic [3:0]  blk_cnt = '0;
  logic        extract = 1'b0;
  logic        busy, fault;
  logic        rd_req, rd_gnt = 1'b0, rd_rvalid = 1'b0;
  logic [31:0] rd_addr;
  logic [63:0] rd_rdata = '0;
  logic        wr_req, wr_gnt = 1'b0, wr_ack = 1'b0;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic        dm_valid, dm_ready = 1'b0, dm_last;
  logic [31:0] dm_ptr, dm_info;
  logic [15:0] dm_len;
  logic        irq_frame, irq_list;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwalk_top u_dwalk_top (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start_ptr(start_ptr), .blk_cnt(blk_cnt),
    .extract(extract), .busy(busy), .fault(fault),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt), .wr_ack(wr_ack),
    .dm_valid(dm_valid), .dm_ready(dm_ready), .dm_ptr(dm_ptr), .dm_len(dm_len),
    .dm_info(dm_info), .dm_last(dm_last), .irq_frame(irq_frame), .irq_list(irq_list)
  );

  int tests = 0;
  int fails = 0;
  logic [63:0] mem [0:511];
  logic [31:0]  exp_rd[$];
  logic [80:0]  exp_of[$];
  logic [31:0]  exp_wa[$];
  logic [63:0]  exp_wd[$];
  int exp_frames, exp_lists, seen_frames, seen_lists;
  bit exp_fault;

  task automatic check(input bit ok, input string tag, input logic [80:0] got, input logic [80:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] blk_base(input int b);
    return 32'h100 + 32'(b) * 32'h100;
  endfunction

  function automatic logic [63:0] wb_expect(input logic [63:0] w, input bit last);
    return {w[63:32], 1'b1, last, w[29:0]};
  endfunction

  // memory read model
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] a = '0;
    forever begin
      @(negedge clk);
      rd_gnt = 1'b0; rd_rvalid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_rvalid = 1'b1; rd_rdata = mem[a[11:3]]; pend = 0;
        end else dly--;
      end else if (rd_req && ($urandom % 2 == 0)) begin
        rd_gnt = 1'b1; a = rd_addr; pend = 1; dly = $urandom % 3;
        if (exp_rd.size() == 0) check(0, "R1 unexpected read", 81'(rd_addr), 81'(0));
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          check(rd_addr == e, "R1 read address", 81'(rd_addr), 81'(e));
        end
      end
    end
  end

  // memory write model
  initial begin
    bit pend = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      wr_gnt = 1'b0; wr_ack = 1'b0;
      if (pend) begin
        if (dly == 0) begin wr_ack = 1'b1; pend = 0; end else dly--;
      end else if (wr_req && ($urandom % 2 == 0)) begin
        wr_gnt = 1'b1; pend = 1; dly = $urandom % 3;
        if (exp_wa.size() == 0) check(0, "R4 unexpected write", 81'(wr_addr), 81'(0));
        else begin
          logic [31:0] ea;
          logic [63:0] ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          check(wr_addr == ea, "R4 write address", 81'(wr_addr), 81'(ea));
          check(wr_data == ed, "R4 write data", 81'(wr_data), 81'(ed));
        end
      end
    end
  end

  // data mover model and interrupt monitor
  initial begin
    forever begin
      @(negedge clk);
      dm_ready = 1'b0;
      if (irq_frame) seen_frames++;
      if (irq_list)  seen_lists++;
      if (dm_valid && ($urandom % 2 == 0)) begin
        dm_ready = 1'b1;
        if (exp_of.size() == 0) check(0, "R3 unexpected offer", 81'(dm_ptr), 81'(0));
        else begin
          logic [80:0] e;
          e = exp_of.pop_front();
          check({dm_ptr, dm_len, dm_info, dm_last} == e, "R3 offer fields",
                {dm_ptr, dm_len, dm_info, dm_last}, e);
        end
      end
    end
  end

  // bad_kind: 1 = misaligned buffer pointer, 2 = length not a 128-byte multiple
  task automatic plan_chain(input int nblk, input int cnt, input bit ext,
                            input int bad_blk, input int bad_pair, input int bad_kind,
                            input int bad_next_blk);
    bit stop = 0;
    exp_rd.delete(); exp_of.delete(); exp_wa.delete(); exp_wd.delete();
    exp_frames = 0; exp_lists = 0; exp_fault = 0;
    for (int b = 0; b < nblk; b++) begin
      logic [31:0] base, nextp, info;
      if (stop) break;
      base  = blk_base(b);
      nextp = (b == nblk - 1) ? 32'h0 : blk_base(b + 1);
      if (b == bad_next_blk) nextp = blk_base(b + 1) + 32'h4;
      info  = $urandom;
      mem[base[11:3]]      = {$urandom, nextp};
      mem[base[11:3] + 1]  = {$urandom, info};
      exp_rd.push_back(base);
      exp_rd.push_back(base + 8);
      for (int k = 0; k < cnt; k++) begin
        logic [31:0] ptr, a;
        logic [15:0] len;
        logic [63:0] w;
        bit last;
        ptr  = $urandom & 32'h00ff_fff8;
        len  = 16'((($urandom % 32) + 1) * 128);
        if (b == bad_blk && k == bad_pair) begin
          if (bad_kind == 1) ptr = ptr | 32'h2;
          else len = len + 16'd3;
        end
        w    = {ptr, 2'b00, 14'($urandom), len};
        a    = base + 32'(16 + 8 * k);
        last = (k == cnt - 1);
        mem[a[11:3]] = w;
        exp_rd.push_back(a);
        if (ext && b == bad_blk && k == bad_pair) begin
          stop = 1; exp_fault = 1;
          break;
        end
        exp_of.push_back({ptr, len, info, last});
        exp_wa.push_back(a);
        exp_wd.push_back(wb_expect(w, last));
      end
      if (!stop) begin
        exp_frames++;
        if (nextp == 0) exp_lists++;
        else if (nextp[2:0] != 0) begin exp_fault = 1; stop = 1; end
      end
    end
  endtask

  task automatic run(input logic [31:0] sp, input int cnt, input bit ext,
                     input bit rearm, input string tag);
    int n = 0;
    seen_frames = 0; seen_lists = 0;
    @(negedge clk);
    start_ptr = sp; blk_cnt = 4'(cnt); extract = ext; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    if (rearm) begin
      repeat (6) @(negedge clk);
      check(busy == 1'b1, {tag, " R9 busy before re-arm"}, 81'(busy), 81'(1));
      start_ptr = blk_base(7); blk_cnt = 4'd2; arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
    end
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check(n < 20000, {tag, " walk finished"}, 81'(n), 81'(0));
    check(exp_rd.size() == 0, {tag, " R2 reads outstanding"}, 81'(exp_rd.size()), 81'(0));
    check(exp_of.size() == 0, {tag, " R3 offers missing"}, 81'(exp_of.size()), 81'(0));
    check(exp_wa.size() == 0, {tag, " R4 writes missing"}, 81'(exp_wa.size()), 81'(0));
    check(seen_frames == exp_frames, {tag, " R5 frame irq count"}, 81'(seen_frames), 81'(exp_frames));
    check(seen_lists == exp_lists, {tag, " R6 list irq count"}, 81'(seen_lists), 81'(exp_lists));
    check(fault == exp_fault, {tag, " R7 R8 fault"}, 81'(fault), 81'(exp_fault));
    check(busy == 1'b0, {tag, " idle at end"}, 81'(busy), 81'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({busy, fault, rd_req, wr_req, dm_valid, irq_frame, irq_list} == 7'd0,
          "R10 reset outputs", 81'({busy, fault, rd_req, wr_req, dm_valid, irq_frame, irq_list}), 81'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R6 directed: single block, smallest and largest counts
    plan_chain(1, 1, 1'b0, -1, 0, 0, -1);   run(blk_base(0), 1, 1'b0, 1'b0, "cnt1");
    plan_chain(1, 15, 1'b1, -1, 0, 0, -1);  run(blk_base(0), 15, 1'b1, 1'b0, "cnt15");

    // random chains (R1-style sequencing under random handshakes)
    for (int t = 0; t < 12; t++) begin
      int nb, c;
      bit e;
      nb = 1 + ($urandom % 4);
      c  = 1 + ($urandom % 15);
      e  = 1'($urandom % 2);
      plan_chain(nb, c, e, -1, 0, 0, -1);
      run(blk_base(0), c, e, 1'b0, "random");
    end

    // R8: extraction rejects misaligned pointer and bad length mid-chain
    plan_chain(3, 4, 1'b1, 1, 2, 1, -1);   run(blk_base(0), 4, 1'b1, 1'b0, "R8 ptr");
    plan_chain(2, 3, 1'b1, 1, 0, 2, -1);   run(blk_base(0), 3, 1'b1, 1'b0, "R8 len");
    // R8: injection accepts the same values
    plan_chain(2, 3, 1'b0, 1, 1, 1, -1);   run(blk_base(0), 3, 1'b0, 1'b0, "R8 inj ptr");
    plan_chain(2, 3, 1'b0, 0, 2, 2, -1);   run(blk_base(0), 3, 1'b0, 1'b0, "R8 inj len");

    // R7: misaligned next pointer after a full block
    plan_chain(3, 2, 1'b0, -1, 0, 0, 1);   run(blk_base(0), 2, 1'b0, 1'b0, "R7 next");
    // R7: misaligned start and count 0 issue no read
    plan_chain(0, 1, 1'b0, -1, 0, 0, -1);  exp_fault = 1;
    run(blk_base(0) + 32'h4, 2, 1'b0, 1'b0, "R7 start");
    plan_chain(0, 1, 1'b0, -1, 0, 0, -1);  exp_fault = 1;
    run(blk_base(0), 0, 1'b0, 1'b0, "R7 cnt0");

    // R9: arm while busy ignored; accepted arm clears the fault left above
    plan_chain(2, 6, 1'b0, -1, 0, 0, -1);  run(blk_base(0), 6, 1'b0, 1'b1, "R9 rearm");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule